// File: doc/BRIEF.md
# Timebase-Bit Escalating Watchdog

This block contains a free-running timebase counter and a watchdog that watches one bit of that counter, chosen by a 6-bit period value. Each time the chosen bit goes from 0 to 1, the watchdog counts one event and moves up one stage. The first event sets a pending flag. The second event sets an interrupt flag. The third event sends a one-cycle system reset request to an external reset controller. Software keeps the watchdog quiet by clearing both status flags before the second event arrives.

Software reaches the block through a small register port with single-cycle writes and a combinational read. The port has two registers. The control register holds the period, the interrupt enable and a reset-action code that can be written only once. The status register holds the two escalation flags and a record of the last reset action taken. A period value of zero stops all events. This is how software disables the watchdog after the reset-action code has been locked.

Top module: `tbit_watchdog`

## Requirements
- R1: After reset the timebase, both registers, `intOut` and `rstReq` are all zero.
- R2: The timebase goes up by one on every clock edge where `tickEn` is high and holds its value otherwise. For a period p in 1..TB_W-1 the watched bit is timebase bit TB_W-1-p, so one event occurs every 2^(TB_W-p) ticks.
- R3: If the pending flag (status bit 31) is clear, an event sets it and changes nothing else.
- R4: If the pending flag is set and the interrupt flag (status bit 30) is clear, an event sets the interrupt flag. `intOut` equals the interrupt flag ANDed with the interrupt enable (control bit 26). The flag is set even when the enable is off.
- R5: If both flags are set, an event with a nonzero reset-action code (control bits 29:28) does two things on the next clock edge: it raises `rstReq` for exactly one cycle, and it copies the code into the last-reset field (status bits 29:28). With a zero code, such an event does nothing.
- R6: Writing 1 to status bit 31 clears the pending flag, and writing 1 to status bit 30 clears the interrupt flag. Writing 0 has no effect. If a clear and an event-driven set of the same flag happen in the same cycle, the clear wins. Writing both bits as 1 returns the watchdog to its first stage.
- R7: The register map is as follows.
  - Address 0 is the control register. Period bits 1:0 sit at control bits 31:30. Period bits 5:2 sit at control bits 20:17.
  - Address 1 is the status register.
  - Any other address reads as zero. Unused bits read as zero.
  - Once the reset-action code is nonzero, writes to it are ignored until reset.
- R8: A period of 0, or a period of TB_W or more, selects no bit. In that case no events occur, however long the timebase runs.
- R9: In the cycle after any control-register write, no event is detected. Changing the period therefore never produces a false rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Advances the timebase by one when high |
| regAddr | input | ADDR_W | Register address (0 control, 1 status) |
| regWe | input | 1 | Write strobe, one write per cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| intOut | output | 1 | Interrupt: interrupt flag gated by the enable |
| rstReq | output | 1 | One-cycle system reset request |
| timebase | output | TB_W | Current timebase count |

## Verification
The hardest case to reach from the ports is a period change that would look like a rising edge. For this, the timebase must hold a 1 in the newly chosen bit while the previously watched bit read 0. The bench reaches it by stopping `tickEn` and disabling the period. It then reads the frozen timebase, finds a set bit and writes the period that selects that bit. It then confirms that the pending flag stays clear. Reaching the third stage needs a timebase narrow enough for several events to fit into a short run, so the bench shrinks TB_W to 10.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int PER_W  = 6;
  localparam int DATA_W = 32;
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  // control register field positions
  localparam int C_PLO_HI  = 31;
  localparam int C_PLO_LO  = 30;
  localparam int C_RA_HI   = 29;
  localparam int C_RA_LO   = 28;
  localparam int C_IEN     = 26;
  localparam int C_PHI_HI  = 20;
  localparam int C_PHI_LO  = 17;
  // status register field positions
  localparam int S_PEND    = 31;
  localparam int S_IRQ     = 30;
  localparam int S_LAST_HI = 29;
  localparam int S_LAST_LO = 28;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic             cfgWr;
  } dpCtl_t;
endpackage

// File: rtl/tbw_datapath.sv
module tbw_datapath
  import tbw_pkg::*;
#(
  parameter int TB_W = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tickEn,
  input  dpCtl_t          ctl,
  output logic            evt,
  output logic [TB_W-1:0] timebase
);
  localparam int MAX_P = (1 << PER_W) - 1;

  logic [TB_W-1:0] hit;
  logic selBit, prevBit, maskQ;

  // one decode per timebase bit; bit TB_W-1 would need period 0, which is off
  for (genvar i = 0; i < TB_W; i++) begin : g_sel
    if (i == TB_W - 1 || (TB_W - 1 - i) > MAX_P) begin : g_none
      assign hit[i] = 1'b0;
    end else begin : g_tap
      assign hit[i] = timebase[i] && (ctl.period == PER_W'(TB_W - 1 - i));
    end
  end

  assign selBit = |hit;
  assign evt    = selBit && !prevBit && !maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timebase <= '0;
      prevBit  <= 1'b0;
      maskQ    <= 1'b0;
    end else begin
      if (tickEn) timebase <= timebase + 1'b1;
      prevBit <= selBit;
      maskQ   <= ctl.cfgWr;
    end
  end

  assert_tb_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> timebase == $past(timebase) + 1'b1);
  assert_tb_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timebase));
  assert_no_evt_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.period == '0) |-> !evt);
  assert_no_evt_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.cfgWr) |-> !evt);
endmodule

// File: rtl/tbw_control.sv
module tbw_control
  import tbw_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              evt,
  output dpCtl_t            ctl,
  output logic [DATA_W-1:0] regRdata,
  output logic              intOut,
  output logic              rstReq
);
  logic [PER_W-1:0] period;
  logic       intEn, enNext, intSts;
  logic [1:0] rstCtl, lastRst;
  logic       wrCtl, wrSts, clrPend, clrIrq, fire;

  assign wrCtl   = regWe && (regAddr == ADDR_W'(CTRL_ADDR));
  assign wrSts   = regWe && (regAddr == ADDR_W'(STAT_ADDR));
  assign clrPend = wrSts && regWdata[S_PEND];
  assign clrIrq  = wrSts && regWdata[S_IRQ];
  assign fire    = evt && enNext && intSts && (rstCtl != 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period  <= '0;
      intEn   <= 1'b0;
      rstCtl  <= 2'b00;
      lastRst <= 2'b00;
      enNext  <= 1'b0;
      intSts  <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      if (wrCtl) begin
        period <= {regWdata[C_PHI_HI:C_PHI_LO], regWdata[C_PLO_HI:C_PLO_LO]};
        intEn  <= regWdata[C_IEN];
        if (rstCtl == 2'b00) rstCtl <= regWdata[C_RA_HI:C_RA_LO];
      end
      if (clrPend)              enNext <= 1'b0;
      else if (evt && !enNext)  enNext <= 1'b1;
      if (clrIrq)                        intSts <= 1'b0;
      else if (evt && enNext && !intSts) intSts <= 1'b1;
      rstReq <= fire;
      if (fire) lastRst <= rstCtl;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(CTRL_ADDR)) begin
      regRdata[C_PLO_HI:C_PLO_LO] = period[1:0];
      regRdata[C_PHI_HI:C_PHI_LO] = period[5:2];
      regRdata[C_RA_HI:C_RA_LO]   = rstCtl;
      regRdata[C_IEN]             = intEn;
    end else if (regAddr == ADDR_W'(STAT_ADDR)) begin
      regRdata[S_PEND]              = enNext;
      regRdata[S_IRQ]               = intSts;
      regRdata[S_LAST_HI:S_LAST_LO] = lastRst;
    end
  end

  assign intOut     = intSts && intEn;
  assign ctl.period = period;
  assign ctl.cfgWr  = wrCtl;

  assert_first_event_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evt && !enNext && !clrPend) |=> enNext);
  assert_irq_after_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intSts) |-> $past(enNext));
  assert_rst_needs_stages_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(enNext && intSts && rstCtl != 2'b00));
  assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrPend |=> !enNext);
  assert_code_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rstCtl != 2'b00) |=> rstCtl == $past(rstCtl));
endmodule

// File: rtl/tbit_watchdog.sv
module tbit_watchdog
  import tbw_pkg::*;
#(
  parameter int TB_W   = 64,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              intOut,
  output logic              rstReq,
  output logic [TB_W-1:0]   timebase
);
  dpCtl_t ctl;
  logic   evt;

  tbw_datapath #(.TB_W(TB_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctl(ctl),
    .evt(evt), .timebase(timebase)
  );

  tbw_control #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .evt(evt), .ctl(ctl), .regRdata(regRdata),
    .intOut(intOut), .rstReq(rstReq)
  );
endmodule

// File: tb/tbit_watchdog_test.sv
module tbit_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int TB_W = 10;
  localparam int ADDR_W = 2;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic intOut, rstReq;
  logic [TB_W-1:0] timebase;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  tbit_watchdog #(.TB_W(TB_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .intOut(intOut), .rstReq(rstReq),
    .timebase(timebase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mkCtrl(input int p, input bit ien, input int ra);
    logic [5:0] pv = 6'(p);
    logic [1:0] rv = 2'(ra);
    return {pv[1:0], rv, 1'b0, ien, 5'b0, pv[5:2], 17'b0};
  endfunction

  // behavioural reference model
  logic [TB_W-1:0] mTb;
  int mPer, mRa, mLast;
  bit mIen, mPend, mIrq, mPrev, mMask, mRq;

  always @(posedge clk) begin
    if (!rstN) begin
      mTb = '0; mPer = 0; mRa = 0; mLast = 0;
      mIen = 0; mPend = 0; mIrq = 0; mPrev = 0; mMask = 0; mRq = 0;
    end else begin
      bit cur, ev, nPend, nIrq;
      cur = (mPer >= 1 && mPer <= TB_W-1) ? mTb[TB_W-1-mPer] : 1'b0;
      ev = cur && !mPrev && !mMask;
      mRq = ev && mPend && mIrq && (mRa != 0);
      if (mRq) mLast = mRa;
      nPend = mPend; nIrq = mIrq;
      if (regWe && regAddr == 1 && regWdata[31]) nPend = 0;
      else if (ev && !mPend) nPend = 1;
      if (regWe && regAddr == 1 && regWdata[30]) nIrq = 0;
      else if (ev && mPend && !mIrq) nIrq = 1;
      mPend = nPend; mIrq = nIrq;
      if (regWe && regAddr == 0) begin
        mPer = int'({regWdata[20:17], regWdata[31:30]});
        mIen = regWdata[26];
        if (mRa == 0) mRa = int'(regWdata[29:28]);
      end
      mMask = regWe && regAddr == 0;
      mPrev = cur;
      if (tickEn) mTb = mTb + 1'b1;
    end
  end

  function automatic logic [31:0] modelRead(input int a);
    if (a == 0) return mkCtrl(mPer, mIen, mRa);
    if (a == 1) return {mPend, mIrq, 2'(mLast), 28'b0};
    return 32'b0;
  endfunction

  // per-clock comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      check("R7 regRdata vs model", regRdata, modelRead(int'(regAddr)));
      check("R4 intOut vs model", intOut, mIen && mIrq);
      check("R5 rstReq vs model", rstReq, mRq);
      check("R2 timebase vs model", timebase, mTb);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run hung, got cycles=%0d expected < 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr = ADDR_W'(a); regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    regAddr = ADDR_W'(a);
    #1 d = regRdata;
  endtask

  task automatic waitBit(input int b, output longint tbAt);
    regAddr = ADDR_W'(1);
    tbAt = -1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (regRdata[b]) begin tbAt = longint'(timebase); break; end
    end
  endtask

  task automatic waitRst(output longint tbAt);
    tbAt = -1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (rstReq) begin tbAt = longint'(timebase); break; end
    end
  endtask

  initial begin
    logic [31:0] d;
    longint t1, t2, t3;
    int pulses, pSel;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, d); check("R1 control after reset", d, 0);
    rd(1, d); check("R1 status after reset", d, 0);
    check("R1 intOut after reset", intOut, 0);
    check("R1 rstReq after reset", rstReq, 0);
    check("R1 timebase after reset", timebase, 0);

    // phase A: period 7 (bit 2), interrupt off, zero reset code
    wr(0, mkCtrl(7, 0, 0));
    rd(0, d); check("R7 control readback", d, 32'hC002_0000);
    tickEn = 1'b1;
    waitBit(31, t1);
    rd(1, d); check("R3 first event sets pending only", d, 32'h8000_0000);
    waitBit(30, t2);
    check("R2 interval between events", t2 - t1, 8);
    check("R4 flag set but interrupt gated off", intOut, 0);
    pulses = 0;
    for (int n = 0; n < 40; n++) begin @(negedge clk); if (rstReq) pulses++; end
    check("R5 zero code gives no reset", pulses, 0);
    rd(1, d); check("R5 zero code leaves record", d, 32'hC000_0000);

    // R6 ping
    wr(1, 32'hC000_0000);
    rd(1, d); check("R6 ping clears both flags", d, 0);
    check("R6 interrupt low after ping", intOut, 0);

    // phase B: interrupt on, reset code 2
    wr(0, mkCtrl(7, 1, 2));
    rd(0, d); check("R7 control readback with code", d, 32'hE402_0000);
    waitBit(31, t1);
    waitBit(30, t2);
    check("R4 interrupt output with enable", intOut, 1);
    waitRst(t3);
    check("R2 interval to third event", t3 - t2, 8);
    check("R5 reset request raised", rstReq, 1);
    @(negedge clk);
    check("R5 reset request one cycle", rstReq, 0);
    rd(1, d); check("R5 last reset record", d, 32'hE000_0000);

    // R7 sticky code
    wr(0, mkCtrl(7, 1, 1));
    rd(0, d); check("R7 reset code locked", d, 32'hE402_0000);

    // R8 disabled periods
    wr(0, mkCtrl(0, 0, 0));
    wr(1, 32'hC000_0000);
    rd(0, d); check("R8 period zero readback", d, 32'h2000_0000);
    repeat (300) @(negedge clk);
    rd(1, d); check("R8 period zero no events", d, 32'h2000_0000);
    wr(0, mkCtrl(12, 0, 0));
    wr(1, 32'hC000_0000);
    rd(0, d); check("R7 split period readback", d, 32'h2006_0000);
    repeat (300) @(negedge clk);
    rd(1, d); check("R8 out-of-range period no events", d, 32'h2000_0000);

    // R9 no false edge on period change
    tickEn = 1'b0;
    wr(0, mkCtrl(0, 0, 0));
    wr(1, 32'hC000_0000);
    @(negedge clk);
    pSel = 0;
    for (int i = 0; i < TB_W-1; i++) if (timebase[i]) pSel = TB_W-1-i;
    check("R9 frozen timebase has a usable set bit", pSel != 0, 1);
    wr(0, mkCtrl(pSel, 0, 0));
    repeat (4) @(negedge clk);
    rd(1, d); check("R9 period change makes no event", d, 32'h2000_0000);

    rd(2, d); check("R7 unused address reads zero", d, 0);
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule